// File: doc/BRIEF.md
# Delayed-Branch Program Counter Sequencer

This block sequences the program counter of a 32-bit RISC core whose instructions are all one word wide and whose control transfers have a single delay slot. The block holds the PC register itself. In every cycle that `step` is high, the instruction at `pcOut` executes: the block decodes the word, works out any jump or branch target, and issues a link write when the instruction asks for one. The redirect is not applied to the next PC. It is parked in a one-entry pending-target register, and it takes effect once the following instruction, the delay slot, has executed.

The jump forms covered are: absolute, PC-relative with link, flag-conditional (taken on a set flag or on a clear flag), and register-indirect, where the indirect form comes with and without link. A link writes register 11 with the branch PC plus 8, which is the address after the delay slot. A register jump-and-link samples its target operand in its own cycle, so naming register 11 as the source still jumps to the old value. A control-transfer instruction that sits in another one's delay slot is flagged on `illegalSlot`. It has no effect of its own, and the first redirect still completes.

Top module: `branch_pc_unit`

## Requirements
- R1: While reset is held and after its release, `pcOut` equals the `RESET_PC` parameter (default 0x100), no redirect is pending, and `illegalSlot` is low.
- R2: A step that executes a non-control instruction, or a branch that is not taken, moves the PC to PC+4 on the clock edge, unless an earlier redirect is pending. `nextPc` always shows the value the PC takes on a step.
- R3: After a taken transfer at PC p, the next step executes the delay slot at p+4, and the step after that executes at the target.
- R4: Absolute jumps are subcode 0 (jump) and subcode 1 (jump-and-link). Their target is bits 25:0 sign-extended and shifted left by 2.
- R5: PC-relative transfers are subcodes 2, 3 and 4. Their target is the branch PC plus bits 25:0 sign-extended and shifted left by 2.
- R6: Register jumps are subcode 5 with bits 25:24 = 0 and bits 23:21 = 0. Their target is `regOperand` exactly as given.
- R7: Subcode 1, subcode 2 and register jump-and-link assert `linkWe` in their step cycle, with `linkIdx` = 11 and `linkData` = branch PC + 8.
- R8: Register jump-and-link is subcode 5 with bits 25:24 = 0 and bits 23:21 = 1. Its target is `regOperand` sampled in the branch cycle. A change of `regOperand` during the delay slot does not move the target.
- R9: Subcode 4 is taken only when `condFlag` = 1. Subcode 3 is taken only when `condFlag` = 0.
- R10: Only words with bits 31:30 = 0 are control transfers. Within that group, subcodes 6 to 15 are not transfers, and neither is subcode 5 with any other value of bits 25:21. All such words advance the PC by 4.
- R11: A transfer executed in a delay slot asserts `illegalSlot` in that cycle. This holds whether the earlier branch was taken or not. The illegal transfer writes no link and loads no redirect, and any pending redirect still completes.
- R12: While `step` is low, the PC, the pending redirect and the delay-slot state do not change, and `linkWe` and `illegalSlot` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| step | input | 1 | Instruction at `pcOut` executes this cycle |
| instrWord | input | 32 | Instruction word at `pcOut` |
| regOperand | input | 32 | Source register value for register jumps |
| condFlag | input | 1 | Compare flag for conditional branches |
| pcOut | output | 32 | PC of the instruction being executed |
| nextPc | output | 32 | PC value taken on the next step |
| linkWe | output | 1 | Link register write enable |
| linkIdx | output | 5 | Link register index (11) |
| linkData | output | 32 | Link value, branch PC + 8 |
| illegalSlot | output | 1 | Transfer found in a delay slot |

## Verification
The hardest case to reach is a transfer inside a delay slot while a redirect from the first branch is still pending. A second variant is a branch placed in the slot of a branch that was not taken. In that variant nothing is pending, yet the slot state must still flag it. The stimulus reaches both cases by issuing back-to-back transfer words, taken and not taken. It then checks that the original target is reached and that the PC runs sequentially afterwards. For the register jump-and-link case, the bench changes the register operand during the slot cycle to the value the link would write.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  localparam int unsigned XLEN    = 32;
  localparam int unsigned SUB_W   = 4;
  localparam int unsigned FIELD_W = 26;

  // subcodes inside the control-transfer group (bits 31:30 == 0)
  localparam logic [SUB_W-1:0] SUB_JMP     = 4'd0;
  localparam logic [SUB_W-1:0] SUB_JMPLINK = 4'd1;
  localparam logic [SUB_W-1:0] SUB_RELLINK = 4'd2;
  localparam logic [SUB_W-1:0] SUB_IFCLR   = 4'd3;
  localparam logic [SUB_W-1:0] SUB_IFSET   = 4'd4;
  localparam logic [SUB_W-1:0] SUB_REGJ    = 4'd5;

  typedef enum logic [1:0] {
    TGT_ABS = 2'd0,
    TGT_REL = 2'd1,
    TGT_REG = 2'd2
  } tgtSelT;

  typedef struct packed {
    logic   advance;    // PC register updates this cycle
    logic   redirect;   // next PC comes from the pending target
    logic   capture;    // load the pending target this cycle
    tgtSelT tgtSel;     // which target form to capture
    logic   linkWrite;  // emit a link write this cycle
  } pcuStrobeT;

endpackage

// File: rtl/pcu_ctrl.sv
module pcu_ctrl
  import pcu_pkg::*;
#(
  parameter int unsigned IW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          step,
  input  logic [IW-1:0] instrWord,
  input  logic          condFlag,
  output pcuStrobeT     strobes,
  output logic          illegalSlot
);

  localparam int unsigned SUB_HI = IW - 3;
  localparam int unsigned SUB_LO = IW - 2 - SUB_W;

  logic             inGroup;
  logic [SUB_W-1:0] subCode;
  logic             isAbs;
  logic             isRel;
  logic             isReg;
  logic             isXfer;
  logic             wantLink;
  logic             taken;
  logic             legalXfer;
  logic             inSlot;
  logic             pendValid;
  tgtSelT           selNow;

  assign inGroup = (instrWord[IW-1 -: 2] == 2'b00);
  assign subCode = instrWord[SUB_HI:SUB_LO];

  assign isAbs = inGroup && ((subCode == SUB_JMP) || (subCode == SUB_JMPLINK));
  assign isRel = inGroup && ((subCode == SUB_RELLINK) || (subCode == SUB_IFCLR) ||
                             (subCode == SUB_IFSET));
  assign isReg = inGroup && (subCode == SUB_REGJ) && (instrWord[25:24] == 2'b00) &&
                 ((instrWord[23:21] == 3'd0) || (instrWord[23:21] == 3'd1));
  assign isXfer = isAbs || isRel || isReg;

  assign wantLink = (inGroup && ((subCode == SUB_JMPLINK) || (subCode == SUB_RELLINK))) ||
                    (isReg && (instrWord[23:21] == 3'd1));

  always_comb begin
    if (inGroup && (subCode == SUB_IFCLR))      taken = !condFlag;
    else if (inGroup && (subCode == SUB_IFSET)) taken = condFlag;
    else                                        taken = 1'b1;
  end

  always_comb begin
    if (isReg)      selNow = TGT_REG;
    else if (isRel) selNow = TGT_REL;
    else            selNow = TGT_ABS;
  end

  assign legalXfer   = step && isXfer && !inSlot;
  assign illegalSlot = step && isXfer && inSlot;

  always_comb begin
    strobes.advance   = step;
    strobes.redirect  = pendValid;
    strobes.capture   = legalXfer && taken;
    strobes.tgtSel    = selNow;
    strobes.linkWrite = legalXfer && wantLink;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inSlot    <= 1'b0;
      pendValid <= 1'b0;
    end else if (step) begin
      inSlot    <= legalXfer;
      pendValid <= legalXfer && taken;
    end
  end

endmodule

// File: rtl/pcu_datapath.sv
module pcu_datapath
  import pcu_pkg::*;
#(
  parameter int unsigned       AW       = 32,
  parameter int unsigned       FW       = 26,
  parameter logic [AW-1:0]     RESET_PC = 32'h0000_0100
) (
  input  logic          clk,
  input  logic          rstN,
  input  pcuStrobeT     strobes,
  input  logic [AW-1:0] instrWord,
  input  logic [AW-1:0] regOperand,
  output logic [AW-1:0] pcOut,
  output logic [AW-1:0] nextPc,
  output logic [AW-1:0] linkData
);

  localparam int unsigned EXT_W = AW - FW - 2;
  localparam logic [AW-1:0] WORD_BYTES = AW'(4);

  logic [AW-1:0] pcReg;
  logic [AW-1:0] pendTarget;
  logic [AW-1:0] fieldScaled;
  logic [AW-1:0] pcPlus4;
  logic [AW-1:0] target;

  assign fieldScaled = {{EXT_W{instrWord[FW-1]}}, instrWord[FW-1:0], 2'b00};
  assign pcPlus4     = pcReg + WORD_BYTES;
  assign linkData    = pcPlus4 + WORD_BYTES;

  always_comb begin
    unique case (strobes.tgtSel)
      TGT_REL: target = pcReg + fieldScaled;
      TGT_REG: target = regOperand;
      default: target = fieldScaled;
    endcase
  end

  assign nextPc = strobes.redirect ? pendTarget : pcPlus4;
  assign pcOut  = pcReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcReg      <= RESET_PC;
      pendTarget <= RESET_PC;
    end else begin
      if (strobes.advance) pcReg <= nextPc;
      if (strobes.capture) pendTarget <= target;
    end
  end

endmodule

// File: rtl/branch_pc_unit.sv
module branch_pc_unit
  import pcu_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0000_0100,
  parameter int unsigned LINK_REG = 11
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        step,
  input  logic [31:0] instrWord,
  input  logic [31:0] regOperand,
  input  logic        condFlag,
  output logic [31:0] pcOut,
  output logic [31:0] nextPc,
  output logic        linkWe,
  output logic [4:0]  linkIdx,
  output logic [31:0] linkData,
  output logic        illegalSlot
);

  pcuStrobeT strobes;

  pcu_ctrl #(.IW(XLEN)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .step       (step),
    .instrWord  (instrWord),
    .condFlag   (condFlag),
    .strobes    (strobes),
    .illegalSlot(illegalSlot)
  );

  pcu_datapath #(.AW(XLEN), .FW(FIELD_W), .RESET_PC(RESET_PC)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .instrWord (instrWord),
    .regOperand(regOperand),
    .pcOut     (pcOut),
    .nextPc    (nextPc),
    .linkData  (linkData)
  );

  assign linkWe  = strobes.linkWrite;
  assign linkIdx = 5'(LINK_REG);

endmodule

// File: rtl/branch_pc_unit_chk.sv
module branch_pc_unit_chk #(
  parameter logic [31:0] RESET_PC = 32'h0000_0100
) (
  input logic        clk,
  input logic        rstN,
  input logic        step,
  input logic [31:0] pcOut,
  input logic        linkWe,
  input logic        illegalSlot
);

  // R1: first cycle out of reset starts at the reset PC
  a_r1_reset_pc: assert property (@(posedge clk)
    (rstN && !$past(rstN)) |-> (pcOut == RESET_PC));

  // R11: an illegal slot transfer never writes the link register
  a_r11_no_link: assert property (@(posedge clk) disable iff (!rstN)
    illegalSlot |-> !linkWe);

  // R12: nothing is flagged without a step
  a_r12_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !step |-> (!illegalSlot && !linkWe));

  // R12: PC holds when no instruction executes
  a_r12_hold: assert property (@(posedge clk) disable iff (!rstN)
    !step |=> $stable(pcOut));

  // R3: the instruction after a linking transfer is its delay slot at PC+4
  a_r3_slot_seq: assert property (@(posedge clk) disable iff (!rstN)
    (step && linkWe) |=> (pcOut == $past(pcOut) + 32'd4));

endmodule

bind branch_pc_unit branch_pc_unit_chk #(.RESET_PC(RESET_PC)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .step       (step),
  .pcOut      (pcOut),
  .linkWe     (linkWe),
  .illegalSlot(illegalSlot)
);

// File: tb/branch_pc_unit_tb.sv
module branch_pc_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RST_PC = 32'h0000_0100;

  typedef struct {
    logic [31:0] pc;
    logic [31:0] npc;
    logic        lwe;
    logic [31:0] ldata;
    logic        ill;
    string       tag;
  } expT;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        step = 1'b0;
  logic [31:0] instrWord = 32'hE000_0000;
  logic [31:0] regOperand = 32'h0;
  logic        condFlag = 1'b0;
  logic [31:0] pcOut, nextPc, linkData;
  logic        linkWe, illegalSlot;
  logic [4:0]  linkIdx;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  expT scoreQ[$];

  // bench model state
  logic [31:0] mPc = RST_PC;
  logic [31:0] mTgt = RST_PC;
  bit          mPend = 1'b0;
  bit          mSlot = 1'b0;

  branch_pc_unit #(.RESET_PC(RST_PC)) u_dut (
    .clk(clk), .rstN(rstN), .step(step), .instrWord(instrWord),
    .regOperand(regOperand), .condFlag(condFlag), .pcOut(pcOut),
    .nextPc(nextPc), .linkWe(linkWe), .linkIdx(linkIdx),
    .linkData(linkData), .illegalSlot(illegalSlot)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check32(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [3:0] sub, input logic [25:0] f);
    return {2'b00, sub, f};
  endfunction

  localparam logic [31:0] NOP_W = {2'b00, 4'd5, 2'b01, 24'h0};
  localparam logic [31:0] ALU_W = 32'hE000_0000;

  // driver: execute one instruction and queue what must be observed
  task automatic exec(input logic [31:0] w, input logic [31:0] op,
                      input logic flag, input string tag);
    bit grp, isAbs, isRel, isReg, isX, link, tk, ill;
    logic [3:0]  sub;
    logic [31:0] sc, tg;
    expT e;
    @(negedge clk);
    step = 1'b1; instrWord = w; regOperand = op; condFlag = flag;
    grp = (w[31:30] == 2'b00);
    sub = w[29:26];
    isAbs = grp && (sub == 4'd0 || sub == 4'd1);
    isRel = grp && (sub == 4'd2 || sub == 4'd3 || sub == 4'd4);
    isReg = grp && sub == 4'd5 && w[25:24] == 2'b00 && (w[23:21] == 3'd0 || w[23:21] == 3'd1);
    isX   = isAbs || isRel || isReg;
    link  = grp && (sub == 4'd1 || sub == 4'd2 || (isReg && w[23:21] == 3'd1));
    tk    = !(grp && sub == 4'd3 && flag) && !(grp && sub == 4'd4 && !flag);
    ill   = isX && mSlot;
    sc    = {{4{w[25]}}, w[25:0], 2'b00};
    tg    = isReg ? op : (isRel ? mPc + sc : sc);
    e.pc = mPc; e.npc = mPend ? mTgt : mPc + 32'd4;
    e.lwe = link && !ill; e.ldata = mPc + 32'd8; e.ill = ill; e.tag = tag;
    scoreQ.push_back(e);
    mPc = e.npc;
    if (isX && !ill) begin
      mSlot = 1'b1; mPend = tk; if (tk) mTgt = tg;
    end else begin
      mSlot = 1'b0; mPend = 1'b0;
    end
  endtask

  task automatic idle(input int n, input string tag);
    expT e;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      step = 1'b0; instrWord = enc(4'd0, 26'h123); condFlag = 1'b1;
      e.pc = mPc; e.npc = mPend ? mTgt : mPc + 32'd4;
      e.lwe = 1'b0; e.ldata = 32'h0; e.ill = 1'b0; e.tag = tag;
      scoreQ.push_back(e);
    end
  endtask

  // monitor: compare queued expectations away from the clock edge
  initial begin
    expT e;
    forever begin
      @(negedge clk);
      #1;
      if (scoreQ.size() > 0) begin
        e = scoreQ.pop_front();
        check32(e.tag, "pcOut", pcOut, e.pc);
        check32(e.tag, "nextPc", nextPc, e.npc);
        check32(e.tag, "linkWe", {31'h0, linkWe}, {31'h0, e.lwe});
        check32(e.tag, "illegalSlot", {31'h0, illegalSlot}, {31'h0, e.ill});
        if (e.lwe) begin
          check32(e.tag, "linkData", linkData, e.ldata);
          check32(e.tag, "linkIdx", {27'h0, linkIdx}, 32'd11);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check32("R1", "pcOut in reset", pcOut, RST_PC);
    check32("R1", "illegal in reset", {31'h0, illegalSlot}, 32'h0);
    rstN = 1'b1;
    @(negedge clk); #1;
    check32("R1", "pcOut after reset", pcOut, RST_PC);
    check32("R1", "nextPc after reset", nextPc, RST_PC + 32'd4);

    exec(NOP_W, 0, 0, "R2 nop");
    exec(enc(4'd0, 26'h80), 0, 0, "R4 jump");
    exec(NOP_W, 0, 0, "R3 slot");
    exec(ALU_W, 0, 0, "R3 at target");
    exec(enc(4'd1, 26'h100), 0, 0, "R7 jal");
    exec(ALU_W, 0, 0, "R3 jal slot");
    exec(enc(4'd2, 26'h3FF_FFFC), 0, 0, "R5 bal back");
    exec(NOP_W, 0, 0, "R5 slot");
    exec(enc(4'd4, 26'd8), 0, 1, "R9 bf taken");
    exec(NOP_W, 0, 0, "R9 slot");
    exec(enc(4'd4, 26'd8), 0, 0, "R9 bf not taken");
    exec(NOP_W, 0, 1, "R9 slot");
    exec(enc(4'd3, 26'd4), 0, 0, "R9 bnf taken");
    exec(NOP_W, 0, 0, "R9 slot");
    exec(enc(4'd3, 26'd4), 0, 1, "R9 bnf not taken");
    exec(NOP_W, 0, 0, "R9 slot");
    exec(NOP_W, 0, 0, "R2 sequential");
    exec({2'b00, 4'd5, 2'b00, 3'd0, 5'd9, 16'h0}, 32'h0000_1000, 0, "R6 jr");
    exec(NOP_W, 32'hDEAD_0000, 0, "R6 slot");
    exec({2'b00, 4'd5, 2'b00, 3'd1, 5'd11, 16'h0}, 32'h0000_2000, 0, "R8 jalr r11");
    exec(NOP_W, 32'h0000_1008, 0, "R8 slot op changed");
    exec(NOP_W, 0, 0, "R8 at old target");
    exec(enc(4'd0, 26'hC00), 0, 0, "R11 first jump");
    exec(enc(4'd1, 26'h40), 0, 0, "R11 jal in slot");
    exec(NOP_W, 0, 0, "R11 first target");
    exec(NOP_W, 0, 0, "R11 sequential after");
    exec(enc(4'd4, 26'h10), 0, 0, "R11 bf not taken");
    exec(enc(4'd4, 26'h10), 0, 1, "R11 bf in slot");
    exec(NOP_W, 0, 1, "R11 no redirect");
    exec(NOP_W, 0, 0, "R10 nop word");
    exec({2'b00, 4'd5, 2'b00, 3'd2, 21'h0}, 32'h5000, 0, "R10 sub5 op 2");
    exec({2'b00, 4'd5, 2'b11, 3'd0, 21'h0}, 32'h5000, 0, "R10 sub5 hi bits");
    exec(enc(4'd6, 26'h40), 0, 0, "R10 sub6");
    exec({2'b10, 4'd0, 26'h40}, 0, 0, "R10 other group");
    exec({2'b01, 4'd1, 26'h40}, 0, 0, "R10 other group link");
    exec(NOP_W, 0, 0, "R10 still sequential");
    exec(enc(4'd0, 26'h2000), 0, 0, "R12 jump before idle");
    idle(3, "R12 idle pending");
    exec(NOP_W, 0, 0, "R12 slot after idle");
    idle(2, "R12 idle redirect");
    exec(NOP_W, 0, 0, "R12 target after idle");
    exec(enc(4'd0, 26'h10), 0, 0, "R12 jump then idle in slot");
    exec(NOP_W, 0, 0, "R12 slot");
    idle(1, "R12 idle after slot");
    exec(NOP_W, 0, 0, "R12 target");
    idle(2, "R12 drain");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule